// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the register-facing control logic that sits in front of an analog-to-digital converter core. Software programs an enable bit, a start bit, a free-running mode bit, an adjust-select bit and a channel-select field over a small register port. The block turns these into a one-clock start pulse and a held input route (positive input, negative input, gain) for the converter core. The core answers some fixed number of clocks later with a one-clock done strobe and a 10-bit code.

Each result is stored and shown through two 8-bit data registers, either right- or left-adjusted. A completion flag marks each new result. A read lock keeps the two halves of one result together. A channel write made while a conversion runs is held back until that conversion ends. In free-running mode the block starts each conversion itself, one clock after the previous result is taken.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0 (address 0 control, 1 channel select, 2 data low, 3 data high), and `core_start` and `core_gain` are 0.
- R2: A write to the control register (address 0) with bit 0 (enable) and bit 1 (start) set makes `core_start` high for exactly the clock after the write. Control bit 1 then reads 1 until the result is taken. In single mode (control bit 2 clear) it then reads 0.
- R3: A start write with enable clear is ignored: control bit 1 reads 0 and no `core_start` pulse appears.
- R4: With control bit 3 clear (right-adjusted), the data low register shows code[7:0] and the data high register shows code[9:8] in bits 1:0, with zeros above.
- R5: With control bit 3 set (left-adjusted), the data high register shows code[9:2] and the data low register shows code[1:0] in bits 7:6, with zeros below.
- R6: The 5-bit channel select field (address 1) decodes as follows. Bits 4:3 = 00 or 11 select single-ended input bits[2:0], with negative input 0 and gain 00 (bypass). Bits 4:3 = 01 select a differential pair with positive input bits[2:0], negative input 1 and gain 01 (1x). Bits 4:3 = 10 select the same pair with gain 10 (20x). Codes 01001 and 10001 route input 1 to both sides to measure residual offset.
- R7: A channel write made during a conversion leaves `core_pos`, `core_neg` and `core_gain` unchanged until that conversion ends. The new selection is routed at the next start.
- R8: With control bit 2 set, `core_start` rises on the clock after each result is taken, with no software start. Clearing bit 2 lets the running conversion finish and starts no further conversion.
- R9: Clearing enable during a conversion ends it at once. Control bit 1 reads 0, and a later core done strobe changes neither the data registers nor the completion flag.
- R10: Control bit 4 (complete) is set whenever a new result reaches the data registers. Writing 1 to it clears it.
- R11: A read of the data low register locks both data registers until the data high register is read. A result arriving while they are locked is held back. It is written, and the complete flag is set, on the clock of the high read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rd | input | 1 | Register read strobe (triggers the read lock side effects) |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| core_start | output | 1 | One-clock conversion start to the core |
| core_pos | output | 3 | Positive input routed to the core |
| core_neg | output | 3 | Negative input routed to the core |
| core_gain | output | 2 | Gain setting: 00 bypass, 01 1x, 10 20x |
| core_done | input | 1 | One-clock result strobe from the core |
| core_code | input | 10 | Conversion code, valid with `core_done` |

## Verification
A sequencer stuck busy leaves control bit 1 at 1 and never sets the complete flag. A sequencer that drops back to idle too early loses the next free-running restart. Both show up within one conversion time, either on the control register or as a missing `core_start` one clock after `core_done`. A route register reloaded at the wrong moment changes `core_pos`/`core_neg`/`core_gain` in the middle of a conversion, which is visible on the clock after the channel write. A lock or pending-result fault mixes the halves of two results, or sets the complete flag too early; this appears on the next data or control read.

// File: rtl/adc_seq_pkg.sv
// Shared encodings for the conversion sequencer: gain codes, sequencer
// states, register addresses and control-register bit positions.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        GAIN_BYPASS = 2'b00,
        GAIN_X1     = 2'b01,
        GAIN_X20    = 2'b10
    } gain_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // channel-select group field (upper two bits of the select code)
    localparam logic [1:0] GRP_SINGLE = 2'b00;
    localparam logic [1:0] GRP_DIFF1  = 2'b01;
    localparam logic [1:0] GRP_DIFF20 = 2'b10;

    // register addresses
    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_CHAN = 1;
    localparam int unsigned ADDR_DLO  = 2;
    localparam int unsigned ADDR_DHI  = 3;

    // control register bit positions
    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_START = 1;
    localparam int unsigned BIT_FREE  = 2;
    localparam int unsigned BIT_LADJ  = 3;
    localparam int unsigned BIT_DONE  = 4;

endpackage

// File: rtl/adc_chan_decode.sv
// Channel-select decoder.
// Turns the stored select code into a core route: positive input, negative
// input and gain. Single-ended groups bypass the gain stage and drive the
// negative input to 0. Differential groups use input DIFF_NEG as the negative
// side. Assumes the select code is stable while it is sampled.
module adc_chan_decode
    import adc_seq_pkg::*;
#(
    parameter int unsigned IN_W     = 3,
    parameter int unsigned DIFF_NEG = 1
) (
    input  logic [IN_W+1:0] sel,
    output logic [IN_W-1:0] pos,
    output logic [IN_W-1:0] neg,
    output logic [1:0]      gain
);

    localparam logic [IN_W-1:0] NEG_IDX = IN_W'(DIFF_NEG);

    logic [1:0] grp;

    // split the code into group and input index
    always_comb begin
        grp = sel[IN_W+1:IN_W];
        pos = sel[IN_W-1:0];
    end

    // pick negative side and gain from the group
    always_comb begin
        neg  = '0;
        gain = GAIN_BYPASS;
        if (grp == GRP_DIFF1) begin
            neg  = NEG_IDX;
            gain = GAIN_X1;
        end else if (grp == GRP_DIFF20) begin
            neg  = NEG_IDX;
            gain = GAIN_X20;
        end
    end

endmodule

// File: rtl/adc_conv_fsm.sv
// Conversion sequencer.
// Issues a one-clock start pulse to the core and holds the route captured at
// that start for the whole conversion. It accepts the core's done strobe only
// while running and enabled. In free-running mode it relaunches on the clock
// after a result is taken. Assumes the core never answers in the same clock
// as the start pulse. en_nxt is the enable value that will be stored at the
// coming edge, so a disabling write aborts in the same edge.
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned IN_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_nxt,
    input  logic            free_run,
    input  logic            start_req,
    input  logic [IN_W-1:0] sel_pos,
    input  logic [IN_W-1:0] sel_neg,
    input  logic [1:0]      sel_gain,
    input  logic            core_done,
    output logic            busy,
    output logic            core_start,
    output logic [IN_W-1:0] act_pos,
    output logic [IN_W-1:0] act_neg,
    output logic [1:0]      act_gain,
    output logic            take
);

    seq_state_e st_q;
    logic       start_q;
    logic       launch;

    // decide result acceptance and new launches
    always_comb begin
        take   = (st_q == SEQ_RUN) && core_done && en_nxt;
        launch = ((st_q == SEQ_IDLE) && start_req) || (take && free_run);
    end

    // state register: idle/run transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
        end else if (st_q == SEQ_IDLE) begin
            if (start_req) st_q <= SEQ_RUN;
        end else begin
            if (!en_nxt || (core_done && !free_run)) st_q <= SEQ_IDLE;
        end
    end

    // start pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= launch;
    end

    // route capture at each launch, held for the conversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pos  <= '0;
            act_neg  <= '0;
            act_gain <= GAIN_BYPASS;
        end else if (launch) begin
            act_pos  <= sel_pos;
            act_neg  <= sel_neg;
            act_gain <= sel_gain;
        end
    end

    assign busy       = (st_q == SEQ_RUN);
    assign core_start = start_q;

endmodule

// File: rtl/adc_result_regs.sv
// Result store and data-register formatter.
// Keeps the last committed code, a one-entry pending slot for results that
// arrive while the data registers are locked, the read lock and the
// complete flag. It shows the code right- or left-adjusted across two
// REG_W-bit registers. Assumes rd_lo and rd_hi are never high together and
// that RES_W <= 2*REG_W.
module adc_result_regs #(
    parameter int unsigned RES_W = 10,
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [RES_W-1:0] code,
    input  logic             ladj,
    input  logic             rd_lo,
    input  logic             rd_hi,
    input  logic             done_clr,
    output logic [REG_W-1:0] data_lo,
    output logic [REG_W-1:0] data_hi,
    output logic             done_flag,
    output logic             locked
);

    localparam int unsigned PAD = 2 * REG_W - RES_W;

    logic [RES_W-1:0]   res_q;
    logic [RES_W-1:0]   pend_q;
    logic               pend_v_q;
    logic               lock_q;
    logic               done_q;
    logic               defer;
    logic               commit_new;
    logic               commit_pend;
    logic [2*REG_W-1:0] word;

    // decide whether a result goes straight in, waits, or a held one lands
    always_comb begin
        defer       = (lock_q && !rd_hi) || rd_lo;
        commit_new  = take && !defer;
        commit_pend = !take && pend_v_q && rd_hi;
    end

    // read lock: set by low read, released by high read
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_q <= 1'b0;
        else if (rd_hi) lock_q <= 1'b0;
        else if (rd_lo) lock_q <= 1'b1;
    end

    // committed result
    always_ff @(posedge clk) begin
        if (!rst_n)           res_q <= '0;
        else if (commit_new)  res_q <= code;
        else if (commit_pend) res_q <= pend_q;
    end

    // pending slot for results that arrive while locked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (take && defer) begin
            pend_q   <= code;
            pend_v_q <= 1'b1;
        end else if (commit_new || commit_pend) begin
            pend_v_q <= 1'b0;
        end
    end

    // complete flag: set on commit, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)                         done_q <= 1'b0;
        else if (commit_new || commit_pend) done_q <= 1'b1;
        else if (done_clr)                  done_q <= 1'b0;
    end

    // formatting variant chosen by the width relation
    generate
        if (PAD == 0) begin : g_exact
            logic ladj_unused;
            assign ladj_unused = ladj;
            assign word        = res_q;
        end else begin : g_padded
            assign word = ladj ? {res_q, {PAD{1'b0}}} : {{PAD{1'b0}}, res_q};
        end
    endgenerate

    assign data_hi   = word[2*REG_W-1:REG_W];
    assign data_lo   = word[REG_W-1:0];
    assign done_flag = done_q;
    assign locked    = lock_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC conversion control sequencer, top level.
// Holds the control and channel-select registers, decodes register
// accesses, and connects the channel decoder, the sequencer and the result
// store. Reads are combinational on bus_addr; bus_rd only marks a read for
// its lock side effects. Assumes a single-cycle write/read strobe per access.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W    = 10,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned IN_W     = 3,
    parameter int unsigned DIFF_NEG = 1,
    parameter int unsigned ADDR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              core_start,
    output logic [IN_W-1:0]   core_pos,
    output logic [IN_W-1:0]   core_neg,
    output logic [1:0]        core_gain,
    input  logic              core_done,
    input  logic [RES_W-1:0]  core_code
);

    localparam int unsigned CH_W = IN_W + 2;

    logic            en_q, free_q, ladj_q;
    logic [CH_W-1:0] chsel_q;
    logic            hit_ctrl, hit_chan, hit_lo, hit_hi;
    logic            wr_ctrl, wr_chan, rd_lo, rd_hi;
    logic            en_nxt, start_req, done_clr;
    logic [IN_W-1:0] dec_pos, dec_neg;
    logic [1:0]      dec_gain;
    logic            busy, take;
    logic [REG_W-1:0] data_lo, data_hi;
    logic            done_flag, res_lock;
    logic            wdata_unused;

    // address decode and access strobes
    always_comb begin
        hit_ctrl  = (bus_addr == ADDR_W'(ADDR_CTRL));
        hit_chan  = (bus_addr == ADDR_W'(ADDR_CHAN));
        hit_lo    = (bus_addr == ADDR_W'(ADDR_DLO));
        hit_hi    = (bus_addr == ADDR_W'(ADDR_DHI));
        wr_ctrl   = bus_wr && hit_ctrl;
        wr_chan   = bus_wr && hit_chan;
        rd_lo     = bus_rd && hit_lo;
        rd_hi     = bus_rd && hit_hi;
        en_nxt    = wr_ctrl ? bus_wdata[BIT_EN] : en_q;
        start_req = wr_ctrl && bus_wdata[BIT_START] && bus_wdata[BIT_EN];
        done_clr  = wr_ctrl && bus_wdata[BIT_DONE];
    end

    // control fields: enable, mode, adjust select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            free_q <= 1'b0;
            ladj_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q   <= bus_wdata[BIT_EN];
            free_q <= bus_wdata[BIT_FREE];
            ladj_q <= bus_wdata[BIT_LADJ];
        end
    end

    // channel-select register (pending selection)
    always_ff @(posedge clk) begin
        if (!rst_n)       chsel_q <= '0;
        else if (wr_chan) chsel_q <= bus_wdata[CH_W-1:0];
    end

    assign wdata_unused = ^bus_wdata[REG_W-1:CH_W];

    adc_chan_decode #(
        .IN_W     (IN_W),
        .DIFF_NEG (DIFF_NEG)
    ) u_decode (
        .sel  (chsel_q),
        .pos  (dec_pos),
        .neg  (dec_neg),
        .gain (dec_gain)
    );

    adc_conv_fsm #(
        .IN_W (IN_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_nxt     (en_nxt),
        .free_run   (free_q),
        .start_req  (start_req),
        .sel_pos    (dec_pos),
        .sel_neg    (dec_neg),
        .sel_gain   (dec_gain),
        .core_done  (core_done),
        .busy       (busy),
        .core_start (core_start),
        .act_pos    (core_pos),
        .act_neg    (core_neg),
        .act_gain   (core_gain),
        .take       (take)
    );

    adc_result_regs #(
        .RES_W (RES_W),
        .REG_W (REG_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .code      (core_code),
        .ladj      (ladj_q),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .done_clr  (done_clr),
        .data_lo   (data_lo),
        .data_hi   (data_hi),
        .done_flag (done_flag),
        .locked    (res_lock)
    );

    // read-data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[BIT_EN]    = en_q;
            bus_rdata[BIT_START] = busy;
            bus_rdata[BIT_FREE]  = free_q;
            bus_rdata[BIT_LADJ]  = ladj_q;
            bus_rdata[BIT_DONE]  = done_flag;
        end else if (hit_chan) begin
            bus_rdata[CH_W-1:0]  = chsel_q;
        end else if (hit_lo) begin
            bus_rdata = data_lo;
        end else if (hit_hi) begin
            bus_rdata = data_hi;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Property checker for the conversion sequencer, bound to its top level.
// It observes the top's ports and the signals the top passes between its
// submodules.
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int unsigned IN_W  = 3,
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             en_nxt,
    input logic             free_q,
    input logic             ladj_q,
    input logic             busy,
    input logic             core_start,
    input logic             core_done,
    input logic             rd_hi,
    input logic             lock,
    input logic [IN_W-1:0]  core_pos,
    input logic [IN_W-1:0]  core_neg,
    input logic [1:0]       core_gain,
    input logic [REG_W-1:0] data_lo,
    input logic [REG_W-1:0] data_hi
);

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start)
        else $error("start pulse longer than one clock");

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> busy)
        else $error("start issued while not running");

    assert_start_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> en_q)
        else $error("start issued with enable clear");

    assert_bypass_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gain == GAIN_BYPASS) |-> (core_neg == '0))
        else $error("bypass route with nonzero negative input");

    assert_gain_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_gain != 2'b11)
        else $error("illegal gain code");

    assert_route_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !core_start) |-> $stable({core_pos, core_neg, core_gain}))
        else $error("route changed during a conversion");

    assert_free_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && core_done && free_q && en_nxt) |=> core_start)
        else $error("free-running restart missing");

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en_nxt) |=> !busy)
        else $error("disable did not stop the conversion");

    assert_lock_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !rd_hi) |=> (!$stable(ladj_q) || $stable({data_hi, data_lo})))
        else $error("data registers changed while locked");

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .IN_W  (IN_W),
    .REG_W (REG_W)
) u_adc_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .en_nxt     (en_nxt),
    .free_q     (free_q),
    .ladj_q     (ladj_q),
    .busy       (busy),
    .core_start (core_start),
    .core_done  (core_done),
    .rd_hi      (rd_hi),
    .lock       (res_lock),
    .core_pos   (core_pos),
    .core_neg   (core_neg),
    .core_gain  (core_gain),
    .data_lo    (data_lo),
    .data_hi    (data_hi)
);

// File: tb/test_adc_seq_ctrl.sv
// Bench for the conversion sequencer: a table of channel/format/code
// vectors walked by one loop, then directed tests for the corner cases.
module test_adc_seq_ctrl;

    localparam int LAT = 5;

    typedef struct packed {
        logic [4:0] chan;
        logic       ladj;
        logic [9:0] code;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [2:0] pos;
        logic [2:0] neg;
        logic [1:0] gain;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{5'b00011, 1'b0, 10'h3FF, 8'hFF, 8'h03, 3'd3, 3'd0, 2'd0},
        '{5'b01001, 1'b0, 10'h005, 8'h05, 8'h00, 3'd1, 3'd1, 2'd1},
        '{5'b10110, 1'b1, 10'h2C3, 8'hC0, 8'hB0, 3'd6, 3'd1, 2'd2},
        '{5'b11101, 1'b1, 10'h001, 8'h40, 8'h00, 3'd5, 3'd0, 2'd0},
        '{5'b01111, 1'b0, 10'h200, 8'h00, 8'h02, 3'd7, 3'd1, 2'd1},
        '{5'b10001, 1'b1, 10'h3FF, 8'hC0, 8'hFF, 3'd1, 3'd1, 2'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       core_start;
    logic [2:0] core_pos, core_neg;
    logic [1:0] core_gain;
    logic       core_done = 1'b0;
    logic [9:0] core_code = '0;

    logic [9:0] next_code = '0;
    int         cnt = 0;
    int         n_start = 0;
    int         n_tight = 0;
    logic       done_prev = 1'b0;
    logic [2:0] cap_pos = '0, cap_neg = '0;
    logic [1:0] cap_gain = '0;
    int         n_total = 0;
    int         n_bad = 0;
    logic [7:0] rd;

    always #4 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .core_start (core_start),
        .core_pos   (core_pos),
        .core_neg   (core_neg),
        .core_gain  (core_gain),
        .core_done  (core_done),
        .core_code  (core_code)
    );

    // converter core model: fixed latency, captures the route at start
    always @(posedge clk) begin
        core_done <= 1'b0;
        done_prev <= core_done;
        if (core_start && done_prev) n_tight <= n_tight + 1;
        if (!rst_n) begin
            cnt <= 0;
        end else if (core_start) begin
            cnt      <= LAT;
            n_start  <= n_start + 1;
            cap_pos  <= core_pos;
            cap_neg  <= core_neg;
            cap_gain <= core_gain;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                core_done <= 1'b1;
                core_code <= next_code;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (LAT + 7) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        n_total++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        int s0, t0, s1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 core_start", core_start, 0);
        check("R1 core_gain", core_gain, 0);
        bus_read(0, rd); check("R1 ctrl", rd, 8'h00);
        bus_read(1, rd); check("R1 chan", rd, 8'h00);
        bus_read(2, rd); check("R1 data lo", rd, 8'h00);
        bus_read(3, rd); check("R1 data hi", rd, 8'h00);

        // table walk: R2 R4 R5 R6 R10
        for (int i = 0; i < 6; i++) begin
            bus_write(1, {3'b0, VEC[i].chan});
            next_code = VEC[i].code;
            bus_write(0, 8'h13 | {4'b0, VEC[i].ladj, 3'b0});
            check("R2 start pulse", core_start, 1);
            bus_read(0, rd); check("R2 start bit while running", rd, 8'h03 | {4'b0, VEC[i].ladj, 3'b0});
            settle();
            bus_read(0, rd); check("R2 R10 start clear, complete set", rd, 8'h11 | {4'b0, VEC[i].ladj, 3'b0});
            bus_read(2, rd); check("R4 R5 data lo", rd, VEC[i].lo);
            bus_read(3, rd); check("R4 R5 data hi", rd, VEC[i].hi);
            check("R6 pos", cap_pos, VEC[i].pos);
            check("R6 neg", cap_neg, VEC[i].neg);
            check("R6 gain", cap_gain, VEC[i].gain);
        end

        // R10: write-one clears complete
        bus_write(0, 8'h11);
        bus_read(0, rd); check("R10 complete cleared", rd, 8'h01);

        // R3: start without enable is ignored
        s0 = n_start;
        bus_write(0, 8'h02);
        bus_read(0, rd); check("R3 start ignored", rd, 8'h00);
        settle();
        check("R3 no core start", n_start, s0);

        // R7: channel write during a conversion is deferred
        bus_write(1, 8'h02);
        next_code = 10'h111;
        bus_write(0, 8'h13);
        bus_write(1, 8'h04);
        check("R7 pos held", core_pos, 3'd2);
        settle();
        check("R7 old channel used", cap_pos, 3'd2);
        bus_read(1, rd); check("R7 new selection stored", rd, 8'h04);
        next_code = 10'h0F0;
        bus_write(0, 8'h13);
        settle();
        check("R7 new channel at next start", cap_pos, 3'd4);
        bus_read(2, rd); check("R4 lo", rd, 8'hF0);
        bus_read(3, rd); check("R4 hi", rd, 8'h00);

        // R9: disable aborts, late done ignored
        next_code = 10'h123;
        bus_write(0, 8'h13);
        repeat (2) @(negedge clk);
        bus_write(0, 8'h00);
        bus_read(0, rd); check("R9 start bit cleared", rd, 8'h00);
        settle();
        bus_read(0, rd); check("R9 no complete", rd, 8'h00);
        bus_read(2, rd); check("R9 lo unchanged", rd, 8'hF0);
        bus_read(3, rd); check("R9 hi unchanged", rd, 8'h00);

        // R11: read lock and held-back result
        next_code = 10'h155;
        bus_write(0, 8'h13);
        settle();
        bus_read(2, rd); check("R11 first lo", rd, 8'h55);
        next_code = 10'h2AA;
        bus_write(0, 8'h13);
        settle();
        bus_read(0, rd); check("R11 complete waits for unlock", rd, 8'h01);
        bus_read(3, rd); check("R11 hi from locked result", rd, 8'h01);
        bus_read(0, rd); check("R11 complete after unlock", rd, 8'h11);
        bus_read(2, rd); check("R11 held result lo", rd, 8'hAA);
        bus_read(3, rd); check("R11 held result hi", rd, 8'h02);

        // R8: free-running restarts, then stop
        bus_write(1, 8'h00);
        s0 = n_start; t0 = n_tight;
        bus_write(0, 8'h17);
        repeat (40) @(negedge clk);
        check("R8 several conversions", (n_start - s0) >= 3, 1);
        check("R8 restart one clock after result", n_tight - t0, n_start - s0 - 1);
        bus_write(0, 8'h01);
        repeat (15) @(negedge clk);
        s1 = n_start;
        repeat (20) @(negedge clk);
        check("R8 no start after mode cleared", n_start, s1);
        bus_read(0, rd); check("R8 idle after last result", rd, 8'h11);

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule